// File: doc/BRIEF.md
# E1/T1 Receive Line Decoder

This block sits behind the receive slicer of a dual-standard line interface. It takes the recovered line symbols as two rails, one for positive marks and one for negative marks, already sampled into the recovered clock domain. It rebuilds the data stream in the format that the static configuration inputs choose. One input selects E1 or T1 framing rules. A second input, active low, enables removal of the zero-substitution codes: HDB3 in E1 and B8ZS in T1.

The output either keeps the two-rail bipolar form or becomes unipolar (NRZ) data. In NRZ form the second rail turns into a one-bit error strobe. It fires for violations that no substitution code explains and for zero runs that are too long. A third input moves the output update from the rising edge to the falling edge of the clock.

Independently of the output path, a zero-run monitor raises a carrier-loss flag when the line has been quiet for too long. The run length that triggers it depends on the E1/T1 choice.

Top module: `e1t1_rx_decoder`

## Requirements
- R1: With `nrz_mode`=0, a mark sampled on `rx_p` (or `rx_n`) at rising edge k appears as a one-bit pulse on `out_p` (or `out_n`) after rising edge k+8, unless a substitution code removes it. Zeros give 0 on both outputs. `rx_p` and `rx_n` are never both 1.
- R2: With `dec_off`=1, no substitution is removed in either mode. Every mark reaches the output, and every violation counts as an error.
- R3: With `sel_t1`=0 and `dec_off`=0, a violation preceded by three zeros (000V) is output as a zero. A violation preceded by two zeros and a non-violating mark (B00V) has both of its marks output as zeros.
- R4: With `sel_t1`=1 and `dec_off`=0, the eight-symbol sequence zero, zero, zero, V, B, zero, V, B (V a violation, B a non-violating mark) is output as eight zeros.
- R5: A violation is a mark with the same polarity as the previous mark sampled since reset, counting marks later removed. With `nrz_mode`=1, `out_p` is 1 for every surviving mark of either polarity. `out_n` is 1 for one bit in the slot of any violation that was not removed.
- R6: With `nrz_mode`=1, `out_n` also pulses once per zero run, in the slot of the zero that pushes the run past its limit. That is the 4th zero in E1 with decoding, the 8th in T1 with decoding and the 16th in T1 without decoding. There is no such pulse in E1 without decoding.
- R7: `carrier_lost` goes to 1 after the rising edge that samples the 255th consecutive zero (E1) or the 192nd (T1). It stays 1 while zeros continue and returns to 0 after the edge that samples a mark.
- R8: With `fall_edge`=1, `out_p` and `out_n` change on the falling edge that follows the rising edge where they would change with `fall_edge`=0.
- R9: `rst_n` low clears the outputs, the carrier-loss flag, the zero count, the symbol window and the polarity history. The first mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_t1 | input | 1 | 0 = E1 rules, 1 = T1 rules |
| dec_off | input | 1 | 0 = remove HDB3/B8ZS substitutions, 1 = pass marks through |
| nrz_mode | input | 1 | 0 = bipolar outputs, 1 = NRZ data plus error strobe |
| fall_edge | input | 1 | 0 = outputs change on rising edge, 1 = on falling edge |
| rx_p | input | 1 | Positive-mark rail, sampled on the rising edge |
| rx_n | input | 1 | Negative-mark rail, sampled on the rising edge |
| out_p | output | 1 | Positive marks (bipolar) or data (NRZ) |
| out_n | output | 1 | Negative marks (bipolar) or error strobe (NRZ) |
| carrier_lost | output | 1 | Loss-of-carrier flag from the zero-run count |

## Verification
The assertions take for granted that the two input rails are never high in the same cycle. They also take for granted that the four configuration inputs stay fixed while reset is released. The polarity history, the zero-count bound on the carrier-loss flag and the pattern matches are only meaningful under those conditions. The stimulus builds every mark through helper tasks that drive exactly one rail, including the deliberate violations. It changes the configuration only while reset is held low.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;

  // One line symbol as it moves through the decode window.
  typedef struct packed {
    logic mark;   // a pulse was received in this bit slot
    logic pos;    // pulse polarity, 1 = positive rail
    logic viol;   // pulse repeats the polarity of the previous pulse
    logic exz;    // this zero pushed the run past the excessive-zero limit
  } sym_t;

  // Longest substitution code handled (B8ZS spans eight bit slots).
  localparam int B8ZS_SPAN = 8;

endpackage

// File: rtl/rxdec_zero_mon.sv
module rxdec_zero_mon #(
  parameter int E1_LOS   = 255,
  parameter int T1_LOS   = 192,
  parameter int HDB3_EXZ = 3,
  parameter int B8ZS_EXZ = 7,
  parameter int AMI_EXZ  = 15,
  parameter int CNT_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_t1,
  input  logic dec_off,
  input  logic mark_i,
  output logic exz_o,
  output logic los_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0] zcnt_q, zcnt_n;
  logic [CNT_W-1:0] los_thr, exz_lim;
  logic             exz_en;
  logic             los_q, los_n;

  // Limit and threshold selection follow the line standard and decode setting.
  always_comb begin
    los_thr = sel_t1 ? CNT_W'(T1_LOS) : CNT_W'(E1_LOS);
    exz_en  = 1'b1;
    exz_lim = '0;
    case ({sel_t1, dec_off})
      2'b00:   exz_lim = CNT_W'(HDB3_EXZ + 1);
      2'b10:   exz_lim = CNT_W'(B8ZS_EXZ + 1);
      2'b11:   exz_lim = CNT_W'(AMI_EXZ + 1);
      default: exz_en  = 1'b0;
    endcase
  end

  // Run counter saturates; the flag holds between a threshold hit and a mark.
  always_comb begin
    if (mark_i)
      zcnt_n = '0;
    else if (zcnt_q == CNT_SAT)
      zcnt_n = zcnt_q;
    else
      zcnt_n = zcnt_q + CNT_W'(1);

    exz_o = exz_en & ~mark_i & (zcnt_n == exz_lim);

    if (mark_i)
      los_n = 1'b0;
    else if (zcnt_n >= los_thr)
      los_n = 1'b1;
    else
      los_n = los_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
      los_q  <= 1'b0;
    end else begin
      zcnt_q <= zcnt_n;
      los_q  <= los_n;
    end
  end

  assign los_o = los_q;

  // An excess-zero tag can only come after a run already in progress.
  assert_exz_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exz_o |-> (zcnt_q != '0));

  // The carrier-loss flag never stands without a long enough run behind it.
  assert_los_backed_by_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    los_q |-> (zcnt_q >= los_thr));

endmodule

// File: rtl/rxdec_subst_win.sv
module rxdec_subst_win
  import rxdec_pkg::*;
#(
  parameter int DEPTH = B8ZS_SPAN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_t1,
  input  logic dec_off,
  input  logic in_mark,
  input  logic in_pos,
  input  logic in_exz,
  output sym_t exit_o
);

  sym_t win_q [DEPTH];
  sym_t win_n [DEPTH];
  sym_t cand  [DEPTH+1];
  logic [DEPTH:0] clr;

  logic last_pos_q, last_pos_n;
  logic seen_q, seen_n;
  logic in_viol;
  logic dec_e1, dec_t1;
  logic hdb_zero, hdb_bv, b8_hit;

  // cand[0] is the symbol arriving now; cand[i] is the one i slots older.
  always_comb begin
    in_viol = in_mark & seen_q & (in_pos == last_pos_q);
    cand[0] = '{mark: in_mark, pos: in_pos, viol: in_viol, exz: in_exz};
    for (int i = 1; i <= DEPTH; i++) cand[i] = win_q[i-1];
  end

  // Pattern recognition on the newest symbols.
  always_comb begin
    dec_e1   = ~sel_t1 & ~dec_off;
    dec_t1   =  sel_t1 & ~dec_off;
    hdb_zero = dec_e1 & cand[0].viol & ~cand[1].mark & ~cand[2].mark & ~cand[3].mark;
    hdb_bv   = dec_e1 & cand[0].viol & ~cand[1].mark & ~cand[2].mark &
               cand[3].mark & ~cand[3].viol;
    b8_hit   = dec_t1 & cand[0].mark & ~cand[0].viol & cand[1].viol & ~cand[2].mark &
               cand[3].mark & ~cand[3].viol & cand[4].viol &
               ~cand[5].mark & ~cand[6].mark & ~cand[7].mark;
    clr      = '0;
    clr[0]   = hdb_zero | hdb_bv | b8_hit;
    clr[1]   = b8_hit;
    clr[3]   = hdb_bv | b8_hit;
    clr[4]   = b8_hit;
  end

  // Shift by one slot, blanking the marks of a recognized substitution.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      win_n[i] = cand[i];
      if (clr[i]) begin
        win_n[i].mark = 1'b0;
        win_n[i].viol = 1'b0;
      end
    end
    last_pos_n = in_mark ? in_pos : last_pos_q;
    seen_n     = seen_q | in_mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) win_q[i] <= win_n[i];
      last_pos_q <= last_pos_n;
      seen_q     <= seen_n;
    end
  end

  assign exit_o = win_q[DEPTH-1];

  // A violation leaving the window must still carry its pulse.
  assert_exit_viol_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_q[DEPTH-1].viol |-> win_q[DEPTH-1].mark);

  // Polarity history, once started, persists until the next reset.
  assert_history_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> seen_q);

endmodule

// File: rtl/rxdec_out_stage.sv
module rxdec_out_stage
  import rxdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_mode,
  input  logic fall_edge,
  input  sym_t exit_i,
  output logic out_p,
  output logic out_n
);

  logic [1:0] rise_n, rise_q, fall_q;

  always_comb begin
    if (nrz_mode)
      rise_n = {exit_i.mark, exit_i.viol | exit_i.exz};
    else
      rise_n = {exit_i.mark & exit_i.pos, exit_i.mark & ~exit_i.pos};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= rise_n;
  end

  // Half-cycle retimed copy for falling-edge output timing.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= rise_q;
  end

  assign {out_p, out_n} = fall_edge ? fall_q : rise_q;

  // At each rising edge the retimed copy has caught up with the rising stage.
  assert_fall_tracks_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q == rise_q);

endmodule

// File: rtl/e1t1_rx_decoder.sv
module e1t1_rx_decoder
  import rxdec_pkg::*;
#(
  parameter int E1_LOS_ZEROS   = 255,
  parameter int T1_LOS_ZEROS   = 192,
  parameter int HDB3_EXZ_LIMIT = 3,
  parameter int B8ZS_EXZ_LIMIT = 7,
  parameter int AMI_EXZ_LIMIT  = 15,
  parameter int WIN_DEPTH      = B8ZS_SPAN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_t1,
  input  logic dec_off,
  input  logic nrz_mode,
  input  logic fall_edge,
  input  logic rx_p,
  input  logic rx_n,
  output logic out_p,
  output logic out_n,
  output logic carrier_lost
);

  localparam int LOS_MAX = (E1_LOS_ZEROS > T1_LOS_ZEROS) ? E1_LOS_ZEROS : T1_LOS_ZEROS;
  localparam int CNT_W   = $clog2(LOS_MAX + 1);

  logic line_mark;
  logic zero_exz;
  sym_t exit_sym;

  assign line_mark = rx_p | rx_n;

  rxdec_zero_mon #(
    .E1_LOS   (E1_LOS_ZEROS),
    .T1_LOS   (T1_LOS_ZEROS),
    .HDB3_EXZ (HDB3_EXZ_LIMIT),
    .B8ZS_EXZ (B8ZS_EXZ_LIMIT),
    .AMI_EXZ  (AMI_EXZ_LIMIT),
    .CNT_W    (CNT_W)
  ) u_zero_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_t1  (sel_t1),
    .dec_off (dec_off),
    .mark_i  (line_mark),
    .exz_o   (zero_exz),
    .los_o   (carrier_lost)
  );

  rxdec_subst_win #(
    .DEPTH (WIN_DEPTH)
  ) u_subst_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_t1  (sel_t1),
    .dec_off (dec_off),
    .in_mark (line_mark),
    .in_pos  (rx_p),
    .in_exz  (zero_exz),
    .exit_o  (exit_sym)
  );

  rxdec_out_stage u_out_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .nrz_mode  (nrz_mode),
    .fall_edge (fall_edge),
    .exit_i    (exit_sym),
    .out_p     (out_p),
    .out_n     (out_n)
  );

  // Input contract: the two rails never carry a pulse in the same slot.
  assert_rails_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_p && rx_n));

  // A received pulse ends carrier loss on the following cycle.
  assert_los_clears_on_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_p || rx_n) |=> !carrier_lost);

  // Carrier loss is only entered on a zero.
  assert_los_rises_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_lost) |-> $past(!(rx_p || rx_n)));

endmodule

// File: tb/e1t1_rx_decoder_test.sv
`timescale 1ns/1ps
module e1t1_rx_decoder_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sel_t1, dec_off, nrz_mode, fall_edge, rx_p, rx_n;
  logic out_p, out_n, carrier_lost;

  e1t1_rx_decoder uut (
    .clk(clk), .rst_n(rst_n), .sel_t1(sel_t1), .dec_off(dec_off),
    .nrz_mode(nrz_mode), .fall_edge(fall_edge), .rx_p(rx_p), .rx_n(rx_n),
    .out_p(out_p), .out_n(out_n), .carrier_lost(carrier_lost)
  );

  int    compared = 0;
  int    mismatched = 0;
  string cur_req = "R9";

  // Reference model state: behavioural symbol history, oldest first.
  bit mk[$], pl[$], vi[$], ez[$];
  bit m_last, m_seen, m_los;
  int m_zrun;
  bit er_p, er_n, ef_p, ef_n;
  bit cfg_t1, cfg_off, cfg_nrz, cfg_fall;
  bit enc_last;

  function automatic void model_reset();
    mk = {}; pl = {}; vi = {}; ez = {};
    for (int i = 0; i < 8; i++) begin
      mk.push_back(1'b0); pl.push_back(1'b0); vi.push_back(1'b0); ez.push_back(1'b0);
    end
    m_last = 0; m_seen = 0; m_los = 0; m_zrun = 0;
    er_p = 0; er_n = 0; ef_p = 0; ef_n = 0;
  endfunction

  function automatic void model_step(bit p, bit n);
    bit mark = p | n;
    bit viol, exz, c0, c1, c3, c4, o_m, o_p, o_v, o_e;
    int lim;
    viol = mark && m_seen && (p == m_last);
    if (mark) begin m_seen = 1; m_last = p; end
    m_zrun = mark ? 0 : ((m_zrun < 255) ? m_zrun + 1 : 255);
    if (mark) m_los = 0;
    else if (m_zrun >= (cfg_t1 ? 192 : 255)) m_los = 1;
    if (!cfg_t1) lim = cfg_off ? -1 : 3;
    else         lim = cfg_off ? 15 : 7;
    exz = !mark && (lim >= 0) && (m_zrun == lim + 1);
    c0 = 0; c1 = 0; c3 = 0; c4 = 0;
    // Index 7 is the newest stored symbol, index 1 the seventh newest.
    if (!cfg_off && !cfg_t1 && viol && !mk[7] && !mk[6]) begin
      if (!mk[5]) c0 = 1;
      else if (!vi[5]) begin c0 = 1; c3 = 1; end
    end
    if (!cfg_off && cfg_t1 && mark && !viol && vi[7] && !mk[6] && mk[5] && !vi[5] &&
        vi[4] && !mk[3] && !mk[2] && !mk[1]) begin
      c0 = 1; c1 = 1; c3 = 1; c4 = 1;
    end
    if (c1) begin mk[7] = 0; vi[7] = 0; end
    if (c3) begin mk[5] = 0; vi[5] = 0; end
    if (c4) begin mk[4] = 0; vi[4] = 0; end
    o_m = mk.pop_front(); o_p = pl.pop_front(); o_v = vi.pop_front(); o_e = ez.pop_front();
    mk.push_back(mark & !c0); pl.push_back(p); vi.push_back(viol & !c0); ez.push_back(exz);
    ef_p = er_p; ef_n = er_n;
    if (cfg_nrz) begin er_p = o_m; er_n = o_v | o_e; end
    else begin er_p = o_m & o_p; er_n = o_m & !o_p; end
  endfunction

  task automatic check_outputs(string req);
    bit ep, en;
    ep = cfg_fall ? ef_p : er_p;
    en = cfg_fall ? ef_n : er_n;
    compared++;
    if (out_p !== ep || out_n !== en || carrier_lost !== m_los) begin
      mismatched++;
      $display("FAIL %s: {out_p,out_n,carrier_lost} actual=%b%b%b expected=%b%b%b at %0t",
               (carrier_lost !== m_los) ? "R7" : req, out_p, out_n, carrier_lost,
               ep, en, m_los, $time);
    end
  endtask

  // All stimulus tasks start and end at a falling edge.
  task automatic sym(bit p, bit n);
    rx_p = p; rx_n = n;
    if (p | n) enc_last = p;
    @(posedge clk);
    model_step(p, n);
    #5 check_outputs(cur_req);
    @(negedge clk);
  endtask

  task automatic zeros(int k);
    for (int i = 0; i < k; i++) sym(0, 0);
  endtask

  task automatic mark_alt();  sym(!enc_last, enc_last); endtask
  task automatic mark_viol(); sym(enc_last, !enc_last); endtask

  task automatic sub_000v(); zeros(3); mark_viol(); endtask
  task automatic sub_b00v(); mark_alt(); zeros(2); mark_viol(); endtask
  task automatic sub_b8zs();
    zeros(3); mark_viol(); mark_alt(); zeros(1); mark_viol(); mark_alt();
  endtask

  task automatic setup(bit t1, bit off, bit nrz, bit fall, string req);
    rst_n = 0; rx_p = 0; rx_n = 0;
    cfg_t1 = t1; cfg_off = off; cfg_nrz = nrz; cfg_fall = fall;
    sel_t1 = t1; dec_off = off; nrz_mode = nrz; fall_edge = fall;
    model_reset();
    enc_last = 0;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #5 check_outputs("R9");   // R9: reset state
      @(negedge clk);
    end
    rst_n = 1;
    cur_req = req;
  endtask

  task automatic traffic(int units, int max_run);
    for (int u = 0; u < units; u++) begin
      int r = $urandom_range(0, 9);
      if (r <= 3) zeros(1);
      else if (r <= 6) mark_alt();
      else if (r == 7) begin
        if (cfg_t1) sub_b8zs();
        else if ($urandom_range(0, 1) == 0) sub_000v();
        else sub_b00v();
      end
      else if (r == 8) mark_viol();
      else zeros($urandom_range(3, max_run));
    end
  endtask

  initial begin
    #3000000;
    mismatched++;
    $display("FAIL R9: watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(11));
    rst_n = 0; rx_p = 0; rx_n = 0;
    sel_t1 = 0; dec_off = 0; nrz_mode = 0; fall_edge = 0;
    @(negedge clk);

    // R1: plain alternating marks and zeros, bipolar, E1 decoding
    setup(0, 0, 0, 0, "R1");
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 2) zeros(1); else mark_alt();
    end
    zeros(10);
    // R3: HDB3 substitutions mixed with traffic
    cur_req = "R3";
    sub_000v(); sub_b00v(); traffic(400, 12); zeros(10);

    // R5: NRZ data and error strobe for unexplained violations
    setup(0, 0, 1, 0, "R5");
    mark_alt(); mark_viol(); mark_viol(); traffic(400, 12); zeros(10);

    // R4: B8ZS in bipolar T1
    setup(1, 0, 0, 0, "R4");
    sub_b8zs(); mark_alt(); sub_b8zs(); traffic(400, 12); zeros(10);

    // R6: excess zeros in T1 with decoding, NRZ
    setup(1, 0, 1, 0, "R6");
    mark_alt(); zeros(7); mark_alt(); zeros(8); mark_alt(); zeros(12);
    traffic(300, 14); zeros(10);

    // R2: T1 without decoding keeps violations, excess zeros at 16
    setup(1, 1, 1, 0, "R2");
    sub_b8zs(); mark_alt(); zeros(15); mark_alt(); zeros(16); mark_alt();
    traffic(300, 20); zeros(20);

    // R2: E1 without decoding, bipolar, every mark passes
    setup(0, 1, 0, 0, "R2");
    sub_000v(); sub_b00v(); traffic(300, 12); zeros(10);

    // R6: E1 without decoding never flags excess zeros
    setup(0, 1, 1, 0, "R6");
    mark_alt(); zeros(20); mark_alt(); traffic(200, 20); zeros(10);

    // R8: falling-edge output timing, bipolar E1 and NRZ T1
    setup(0, 0, 0, 1, "R8");
    traffic(300, 12); zeros(10);
    setup(1, 0, 1, 1, "R8");
    traffic(300, 14); zeros(10);

    // R7: carrier loss in E1 (255 zeros) and T1 (192 zeros)
    setup(0, 0, 1, 0, "R7");
    mark_alt(); zeros(254); zeros(1); zeros(5); mark_alt(); zeros(100); mark_alt(); zeros(10);
    setup(1, 0, 0, 0, "R7");
    mark_alt(); zeros(191); mark_alt(); zeros(192); zeros(3); mark_alt(); zeros(10);

    // R9: reset in mid-stream clears history; first mark after reset is clean
    setup(0, 0, 1, 0, "R9");
    traffic(60, 10);
    setup(0, 0, 1, 0, "R9");
    sym(1, 0); sym(1, 0); zeros(10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule